// File: doc/BRIEF.md
# I2C FIFO Threshold and Drain Event Unit

This unit tracks the receive and transmit FIFO levels of an I2C controller and raises host events. The bit-level engine and the FIFO storage are outside the unit and appear only as push and pop strobes. Software programs a byte threshold for each direction and starts a transfer with a byte count and a direction.

In a receive transfer, the unit raises a ready event each time a full threshold's worth of bytes has arrived. In a transmit transfer, it asks the host for one threshold's worth of bytes whenever the transmit FIFO has room for them. A tail shorter than the threshold gets its own drain event. A drain event therefore appears only when the byte count is not a multiple of the threshold. Setting the threshold equal to a message that fits in the FIFO gives a single ready event.

Events are held in sticky status bits that software clears by writing 1, and an enable mask gates them onto one interrupt line. Two self-clearing bits in the configuration word empty either FIFO, for example after a NACK.

Top module: `i2c_fifo_events`

Receive tracker states: `RX_IDLE` and `RX_RUN`.
- `RX_IDLE` goes to `RX_RUN` on a receive start with a nonzero count.
- `RX_RUN` returns to `RX_IDLE` on the last byte, on `xfer_end`, or on a receive clear.

Transmit tracker states: `TX_IDLE`, `TX_ASK` and `TX_WAIT`.
- `TX_IDLE` goes to `TX_ASK` on a transmit start with a nonzero count.
- `TX_ASK` goes to `TX_WAIT` when it issues a ready or drain request.
- `TX_ASK` goes to `TX_IDLE` when no bytes remain.
- `TX_WAIT` goes back to `TX_ASK` once the host has pushed the whole requested group.
- `TX_ASK` and `TX_WAIT` go to `TX_IDLE` on `xfer_end` or on a transmit clear.

## Requirements
- R1: After reset, both levels, all status bits and `irq` are 0.
- R2: A configuration write loads the transmit threshold code from `cfg_wdata[3:0]` and the receive threshold code from `cfg_wdata[11:8]`; the threshold in bytes is code plus one.
- R3: In a receive transfer, status bit 0 (receive ready) sets on each push that completes a group of threshold bytes, giving floor(length/threshold) events.
- R4: Status bit 1 (receive drain) sets on the final byte if and only if length modulo threshold is nonzero; ready and drain never set together.
- R5: `xfer_end` during a receive transfer sets receive drain if a partial group is pending, and sets nothing otherwise.
- R6: In a transmit transfer, status bit 2 (transmit ready) is raised once for each full group, floor(length/threshold) times in total; each request follows the host's push of the previous group.
- R7: Status bit 3 (transmit drain) is raised once, for the remainder, if and only if length modulo threshold is nonzero.
- R8: No transmit request is raised while the transmit FIFO's free space is smaller than the group being requested.
- R9: A push raises a level by one and a pop lowers it by one; a level stays within 0 to DEPTH.
- R10: A configuration write with bit 14 set zeroes the receive level, clears status bits 1:0 and ends the receive transfer. Bit 6 does the same for the transmit level, status bits 3:2 and the transmit transfer. Neither bit is stored.
- R11: Status bits stay set until a 1 is written to that bit of `sts_w1c`; a new event in the same cycle as its clear leaves the bit set.
- R12: `irq` is high exactly when some status bit is set together with its bit in `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Threshold codes and FIFO clear bits |
| xfer_start | input | 1 | Start of a transfer |
| xfer_rx | input | 1 | Direction for the start: 1 receive, 0 transmit |
| xfer_len | input | LEN_W | Byte count for the transfer |
| xfer_end | input | 1 | Early end of the transfer (stop or NACK) |
| rx_push | input | 1 | Engine writes a byte into the receive FIFO |
| rx_pop | input | 1 | Host reads a byte from the receive FIFO |
| tx_push | input | 1 | Host writes a byte into the transmit FIFO |
| tx_pop | input | 1 | Engine takes a byte from the transmit FIFO |
| sts_w1c | input | 4 | Write-1-to-clear for the status bits |
| irq_en | input | 4 | Interrupt enable mask |
| sts | output | 4 | Sticky status: rx ready, rx drain, tx ready, tx drain |
| irq | output | 1 | Interrupt request |
| rx_level | output | LVL_W | Receive FIFO fill level |
| tx_level | output | LVL_W | Transmit FIFO fill level |

## Verification
The bench sweeps every threshold from 1 to 8 against every length from 1 to 20 in both directions and counts the events. A design that fires drain on exact multiples, or that drops the last full group, shows a wrong count. Early ends with and without a pending partial group catch a drain that depends on the byte count alone. A prefilled transmit FIFO catches a request issued without room. Clears in mid-transfer catch stale status and trackers that keep running after a clear. A set racing a write-1 clear catches a status register that gives the clear priority.

// File: rtl/i2c_fq_pkg.sv
package i2c_fq_pkg;
    typedef enum logic {RX_IDLE, RX_RUN} rx_state_e;
    typedef enum logic [1:0] {TX_IDLE, TX_ASK, TX_WAIT} tx_state_e;

    localparam int ST_RX_RDY = 0;
    localparam int ST_RX_DRN = 1;
    localparam int ST_TX_RDY = 2;
    localparam int ST_TX_DRN = 3;
    localparam int ST_W      = 4;

    localparam int CFG_TX_THR_LSB = 0;
    localparam int CFG_TX_CLR_BIT = 6;
    localparam int CFG_RX_THR_LSB = 8;
    localparam int CFG_RX_CLR_BIT = 14;
endpackage

// File: rtl/fq_level_ctr.sv
module fq_level_ctr #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic do_pop, do_push;

    always_comb begin
        do_pop  = pop && (level != '0);
        do_push = push && ((level != FULL) || do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (clr) begin
            level <= '0;
        end else if (do_push && !do_pop) begin
            level <= level + 1'b1;
        end else if (do_pop && !do_push) begin
            level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/fq_rx_track.sv
module fq_rx_track
    import i2c_fq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [LVL_W-1:0] thr,
    input  logic             push,
    input  logic             stop,
    input  logic             clr,
    output logic             ev_ready,
    output logic             ev_drain
);
    rx_state_e        state_q, state_n;
    logic [LEN_W-1:0] left_q, left_n;
    logic [LVL_W-1:0] grp_q, grp_n, grp_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            left_q  <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_n;
            left_q  <= left_n;
            grp_q   <= grp_n;
        end
    end

    always_comb begin
        state_n  = state_q;
        left_n   = left_q;
        grp_n    = grp_q;
        ev_ready = 1'b0;
        ev_drain = 1'b0;
        grp_inc  = grp_q + 1'b1;
        unique case (state_q)
            RX_IDLE: begin
                if (start && (len != '0)) begin
                    state_n = RX_RUN;
                    left_n  = len;
                    grp_n   = '0;
                end
            end
            RX_RUN: begin
                if (push) begin
                    left_n = left_q - 1'b1;
                    if (grp_inc == thr) begin
                        ev_ready = 1'b1;
                        grp_n    = '0;
                    end else begin
                        grp_n = grp_inc;
                    end
                    if ((left_q == LEN_W'(1)) || stop) begin
                        state_n  = RX_IDLE;
                        ev_drain = (grp_inc != thr);
                    end
                end else if (stop) begin
                    state_n  = RX_IDLE;
                    ev_drain = (grp_q != '0);
                end
            end
        endcase
        if (clr) begin
            state_n  = RX_IDLE;
            left_n   = '0;
            grp_n    = '0;
            ev_ready = 1'b0;
            ev_drain = 1'b0;
        end
    end
endmodule

// File: rtl/fq_tx_track.sv
module fq_tx_track
    import i2c_fq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [LVL_W-1:0] thr,
    input  logic [LVL_W-1:0] free,
    input  logic             push,
    input  logic             stop,
    input  logic             clr,
    output logic             ev_ready,
    output logic             ev_drain
);
    localparam int CW = (LEN_W > LVL_W) ? LEN_W : LVL_W;

    tx_state_e        state_q, state_n;
    logic [LEN_W-1:0] need_q, need_n;
    logic [LVL_W-1:0] grp_q, grp_n;
    logic [CW-1:0]    need_c, thr_c, free_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            need_q  <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_n;
            need_q  <= need_n;
            grp_q   <= grp_n;
        end
    end

    always_comb begin
        state_n  = state_q;
        need_n   = need_q;
        grp_n    = grp_q;
        ev_ready = 1'b0;
        ev_drain = 1'b0;
        need_c   = CW'(need_q);
        thr_c    = CW'(thr);
        free_c   = CW'(free);
        unique case (state_q)
            TX_IDLE: begin
                if (start && (len != '0)) begin
                    state_n = TX_ASK;
                    need_n  = len;
                end
            end
            TX_ASK: begin
                if (need_q == '0) begin
                    state_n = TX_IDLE;
                end else if (need_c >= thr_c) begin
                    if (free_c >= thr_c) begin
                        ev_ready = 1'b1;
                        grp_n    = thr;
                        need_n   = need_q - LEN_W'(thr);
                        state_n  = TX_WAIT;
                    end
                end else if (free_c >= need_c) begin
                    ev_drain = 1'b1;
                    grp_n    = LVL_W'(need_q);
                    need_n   = '0;
                    state_n  = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (push) begin
                    grp_n = grp_q - 1'b1;
                    if (grp_q == LVL_W'(1)) begin
                        state_n = TX_ASK;
                    end
                end
            end
            default: state_n = TX_IDLE;
        endcase
        if (clr || (stop && (state_q != TX_IDLE))) begin
            state_n  = TX_IDLE;
            need_n   = '0;
            grp_n    = '0;
            ev_ready = 1'b0;
            ev_drain = 1'b0;
        end
    end
endmodule

// File: rtl/i2c_fifo_events.sv
module i2c_fifo_events
    import i2c_fq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LEN_W = 8,
    parameter int THR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [15:0]      cfg_wdata,
    input  logic             xfer_start,
    input  logic             xfer_rx,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             xfer_end,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic [3:0]       sts_w1c,
    input  logic [3:0]       irq_en,
    output logic [3:0]       sts,
    output logic             irq,
    output logic [LVL_W-1:0] rx_level,
    output logic [LVL_W-1:0] tx_level
);
    logic [THR_W-1:0] rx_code_q, tx_code_q;
    logic [LVL_W-1:0] rx_thr, tx_thr, tx_free;
    logic             rx_clr, tx_clr;
    logic             rx_rdy_ev, rx_drn_ev, tx_rdy_ev, tx_drn_ev;
    logic [ST_W-1:0]  set_v, clr_mask, sts_q;
    logic             cfg_unused;

    assign cfg_unused = ^cfg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_code_q <= '0;
            tx_code_q <= '0;
        end else if (cfg_wr) begin
            rx_code_q <= cfg_wdata[CFG_RX_THR_LSB +: THR_W];
            tx_code_q <= cfg_wdata[CFG_TX_THR_LSB +: THR_W];
        end
    end

    always_comb begin
        rx_clr  = cfg_wr && cfg_wdata[CFG_RX_CLR_BIT];
        tx_clr  = cfg_wr && cfg_wdata[CFG_TX_CLR_BIT];
        rx_thr  = LVL_W'(rx_code_q) + LVL_W'(1);
        tx_thr  = LVL_W'(tx_code_q) + LVL_W'(1);
        tx_free = LVL_W'(DEPTH) - tx_level;
    end

    fq_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rx_lvl (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rx_push), .pop(rx_pop), .level(rx_level)
    );

    fq_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_tx_lvl (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .pop(tx_pop), .level(tx_level)
    );

    fq_rx_track #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_rx_trk (
        .clk(clk), .rst_n(rst_n),
        .start(xfer_start && xfer_rx), .len(xfer_len), .thr(rx_thr),
        .push(rx_push), .stop(xfer_end), .clr(rx_clr),
        .ev_ready(rx_rdy_ev), .ev_drain(rx_drn_ev)
    );

    fq_tx_track #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_tx_trk (
        .clk(clk), .rst_n(rst_n),
        .start(xfer_start && !xfer_rx), .len(xfer_len), .thr(tx_thr),
        .free(tx_free), .push(tx_push), .stop(xfer_end), .clr(tx_clr),
        .ev_ready(tx_rdy_ev), .ev_drain(tx_drn_ev)
    );

    always_comb begin
        set_v                = '0;
        set_v[ST_RX_RDY]     = rx_rdy_ev;
        set_v[ST_RX_DRN]     = rx_drn_ev;
        set_v[ST_TX_RDY]     = tx_rdy_ev;
        set_v[ST_TX_DRN]     = tx_drn_ev;
        clr_mask             = '0;
        clr_mask[ST_RX_RDY]  = rx_clr;
        clr_mask[ST_RX_DRN]  = rx_clr;
        clr_mask[ST_TX_RDY]  = tx_clr;
        clr_mask[ST_TX_DRN]  = tx_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~sts_w1c & ~clr_mask) | set_v;
        end
    end

    assign sts = sts_q;
    assign irq = |(sts_q & irq_en);
endmodule

// File: rtl/i2c_fifo_events_chk.sv
module i2c_fifo_events_chk #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [15:0]      cfg_wdata,
    input logic             rx_push,
    input logic [3:0]       sts,
    input logic [3:0]       sts_w1c,
    input logic [3:0]       irq_en,
    input logic             irq,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] tx_level
);
    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= LVL_W'(DEPTH)) && (tx_level <= LVL_W'(DEPTH))); // R9

    AST_RX_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level > $past(rx_level)) |-> (rx_level == $past(rx_level) + 1'b1)); // R9

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[14]) |=> ((rx_level == '0) && (sts[1:0] == 2'b00))); // R10

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[6]) |=> ((tx_level == '0) && (sts[3:2] == 2'b00))); // R10

    AST_RX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !sts_w1c[0] && !(cfg_wr && cfg_wdata[14])) |=> sts[0]); // R11

    AST_RX_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> $past(rx_push)); // R3

    AST_RX_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(sts[0]) && $rose(sts[1]))); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |-> !irq); // R12
endmodule

bind i2c_fifo_events i2c_fifo_events_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .rx_push(rx_push), .sts(sts), .sts_w1c(sts_w1c), .irq_en(irq_en),
    .irq(irq), .rx_level(rx_level), .tx_level(tx_level)
);

// File: tb/i2c_fifo_events_bench.sv
`timescale 1ns/1ps
module i2c_fifo_events_bench;
    localparam int DEPTH = 16;
    localparam int LEN_W = 8;
    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [15:0]      cfg_wdata = '0;
    logic             xfer_start = 1'b0, xfer_rx = 1'b0, xfer_end = 1'b0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic             rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [3:0]       sts_w1c, man_w1c = '0, ack_w1c = '0;
    logic [3:0]       irq_en = '0;
    logic [3:0]       sts;
    logic             irq;
    logic [LVL_W-1:0] rx_level, tx_level;
    logic             auto_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int ev_cnt[4] = '{0, 0, 0, 0};
    int base[4];

    assign sts_w1c = auto_ack ? ack_w1c : man_w1c;

    always #10 clk = ~clk;

    i2c_fifo_events #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_i2c_fifo_events (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .xfer_start(xfer_start), .xfer_rx(xfer_rx), .xfer_len(xfer_len),
        .xfer_end(xfer_end), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_pop(tx_pop), .sts_w1c(sts_w1c),
        .irq_en(irq_en), .sts(sts), .irq(irq),
        .rx_level(rx_level), .tx_level(tx_level)
    );

    // Event monitor: counts and acknowledges status bits when enabled
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack) begin
                for (int b = 0; b < 4; b++) if (sts[b]) ev_cnt[b]++;
                ack_w1c = sts;
            end else begin
                ack_w1c = '0;
            end
        end
    end

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog expired (actual: hung, expected: finished)");
        $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err + 1);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic snap();
        for (int b = 0; b < 4; b++) base[b] = ev_cnt[b];
    endtask

    function automatic int got(input int b);
        return ev_cnt[b] - base[b];
    endfunction

    task automatic cfg_write(input int rxc, input int txc, input bit rclr, input bit tclr);
        cfg_wdata = '0;
        cfg_wdata[11:8] = 4'(rxc);
        cfg_wdata[3:0]  = 4'(txc);
        cfg_wdata[14]   = rclr;
        cfg_wdata[6]    = tclr;
        cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic start(input bit rx, input int len);
        xfer_rx = rx;
        xfer_len = LEN_W'(len);
        xfer_start = 1'b1;
        cyc(1);
        xfer_start = 1'b0;
    endtask

    task automatic end_xfer();
        xfer_end = 1'b1;
        cyc(1);
        xfer_end = 1'b0;
    endtask

    task automatic rx_byte(input bit do_pop);
        rx_push = 1'b1;
        cyc(1);
        rx_push = 1'b0;
        rx_pop = do_pop;
        cyc(1);
        rx_pop = 1'b0;
        cyc(1);
    endtask

    task automatic tx_pulses(input bit psh, input int n);
        for (int i = 0; i < n; i++) begin
            tx_push = psh;
            tx_pop = !psh;
            cyc(1);
        end
        tx_push = 1'b0;
        tx_pop = 1'b0;
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 sts", sts, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_level", tx_level, 0);

        // R2 R3 R4: receive sweep, threshold code = threshold - 1
        auto_ack = 1'b1;
        for (int thr = 1; thr <= 8; thr++) begin
            for (int len = 1; len <= 20; len++) begin
                cfg_write(thr - 1, 0, 1'b0, 1'b0);
                snap();
                start(1'b1, len);
                for (int i = 0; i < len; i++) rx_byte(1'b1);
                cyc(3);
                chk("R2 R3 rx ready count", got(0), len / thr);
                chk("R4 rx drain count", got(1), (len % thr) != 0 ? 1 : 0);
            end
        end
        chk("R9 rx level after sweep", rx_level, 0);

        // R6 R7: transmit sweep, host supplies each requested group
        for (int thr = 1; thr <= 8; thr++) begin
            for (int len = 1; len <= 20; len++) begin
                int supplied;
                int seen;
                cfg_write(0, thr - 1, 1'b0, 1'b0);
                snap();
                start(1'b0, len);
                supplied = 0;
                seen = 0;
                while (supplied < len) begin
                    int n;
                    for (int k = 0; k < 20 && (got(2) + got(3)) <= seen; k++) cyc(1);
                    if ((got(2) + got(3)) <= seen) break;
                    seen++;
                    n = (len - supplied) < thr ? (len - supplied) : thr;
                    tx_pulses(1'b1, n);
                    tx_pulses(1'b0, n);
                    supplied += n;
                end
                cyc(4);
                chk("R6 tx ready count", got(2), len / thr);
                chk("R7 tx drain count", got(3), (len % thr) != 0 ? 1 : 0);
                chk("R9 tx level", tx_level, 0);
            end
        end

        // R5: early end with and without a partial group
        cfg_write(3, 0, 1'b0, 1'b0);
        snap();
        start(1'b1, 10);
        for (int i = 0; i < 6; i++) rx_byte(1'b1);
        end_xfer();
        cyc(3);
        chk("R5 ready before end", got(0), 1);
        chk("R5 drain on partial end", got(1), 1);
        snap();
        start(1'b1, 10);
        for (int i = 0; i < 8; i++) rx_byte(1'b1);
        end_xfer();
        cyc(3);
        chk("R5 ready count", got(0), 2);
        chk("R5 no drain on aligned end", got(1), 0);

        // R8: no request without room, then R10 transmit clear
        cfg_write(0, 7, 1'b0, 1'b0);
        tx_pulses(1'b1, 12);
        chk("R9 tx level prefill", tx_level, 12);
        snap();
        start(1'b0, 8);
        cyc(10);
        chk("R8 no tx ready with 4 free", got(2), 0);
        tx_pulses(1'b0, 4);
        cyc(4);
        chk("R8 tx ready once room exists", got(2), 1);
        cfg_write(0, 7, 1'b0, 1'b1);
        cyc(1);
        chk("R10 tx clear level", tx_level, 0);
        cfg_write(0, 7, 1'b0, 1'b0);
        tx_pulses(1'b1, 1);
        chk("R10 tx clear bit not stored", tx_level, 1);
        snap();
        tx_pulses(1'b1, 8);
        cyc(4);
        chk("R10 tx transfer ended by clear", got(2) + got(3), 0);
        cfg_write(0, 0, 1'b0, 1'b1);

        // R9: saturation at both ends
        for (int i = 0; i < 20; i++) begin rx_push = 1'b1; cyc(1); end
        rx_push = 1'b0;
        chk("R9 rx saturates at depth", rx_level, DEPTH);
        for (int i = 0; i < 20; i++) begin rx_pop = 1'b1; cyc(1); end
        rx_pop = 1'b0;
        chk("R9 rx floors at zero", rx_level, 0);

        // R10 receive clear in mid-transfer
        auto_ack = 1'b0;
        cyc(1);
        cfg_write(3, 0, 1'b0, 1'b0);
        start(1'b1, 10);
        for (int i = 0; i < 4; i++) rx_byte(1'b0);
        chk("R3 rx ready pending", sts, 4'b0001);
        cfg_write(3, 0, 1'b1, 1'b0);
        chk("R10 rx clear level", rx_level, 0);
        chk("R10 rx clear status", sts, 0);
        for (int i = 0; i < 5; i++) rx_byte(1'b0);
        end_xfer();
        cyc(2);
        chk("R10 rx transfer ended by clear", sts, 0);
        chk("R10 rx level counts after clear", rx_level, 5);
        cfg_write(0, 0, 1'b1, 1'b0);

        // R11 R12: sticky status and interrupt mask
        start(1'b1, 5);
        rx_byte(1'b1);
        cyc(3);
        chk("R11 rx ready sticky", sts, 4'b0001);
        man_w1c = 4'b0010;
        cyc(1);
        man_w1c = '0;
        chk("R11 other bit clear ignored", sts, 4'b0001);
        irq_en = 4'b0000;
        cyc(1);
        chk("R12 irq masked", irq, 0);
        irq_en = 4'b0010;
        cyc(1);
        chk("R12 irq other enable", irq, 0);
        irq_en = 4'b0001;
        cyc(1);
        chk("R12 irq enabled", irq, 1);
        man_w1c = 4'b0001;
        cyc(1);
        man_w1c = '0;
        chk("R11 w1c clears", sts, 0);
        chk("R12 irq drops", irq, 0);
        rx_push = 1'b1;
        man_w1c = 4'b0001;
        cyc(1);
        rx_push = 1'b0;
        man_w1c = '0;
        chk("R11 set wins over clear", sts, 4'b0001);
        rx_push = 1'b1;
        cyc(1);
        rx_push = 1'b0;
        man_w1c = 4'b1111;
        cyc(1);
        man_w1c = '0;
        irq_en = '0;
        cfg_write(0, 0, 1'b1, 1'b1);
        chk("R10 both clears", 32'(rx_level) + 32'(tx_level) + 32'(sts), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule